// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block holds the settings of one clock root generator behind a small register read/write bus. Software writes the input source select, the pre-divider, the counter mode and the M, N and D counter values into shadow registers. The divider datapath never sees these shadow values directly. It only sees an active copy, and that copy is loaded as a whole when software sets the update bit in the command register. A half-written setting therefore never reaches the divider.

When software requests an update, the bank takes a snapshot of all shadow registers. After a fixed latency of `SYNC_STAGES` cycles it moves the snapshot into the active copy. This latency stands for the hand-off into the generated clock's domain. The update bit reads 1 until the transfer is done, so software can poll it. Per-register dirty flags show which shadow registers hold values that have not yet been applied. A root-enable bit in the command register drives the clock gate through the same latency, and a read-only status bit reports that the root is off.

Top module: `clkroot_cfg_bank`

## Requirements
- R1: After synchronous reset every shadow and active field is zero. The root enable is off, `root_clk_en` is 0, and the command register (offset 0x00) reads 0x8000_0000.
- R2: Writing the configuration register (0x04), M (0x08), N (0x0C) or D (0x10) changes no active output. Reads return only the implemented bits: pre-divider at [DIV_W-1:0], source select at [10:8], mode at [13:12], and M/N/D in [MND_W-1:0]. All other bits read 0.
- R3: Writing 1 to command bit 0 makes bit 0 read 1 from the next cycle. All active outputs load the shadow values present at the request exactly `SYNC_STAGES` cycles after the write edge, and bit 0 clears on that same edge. The active outputs do not change before then.
- R4: Command bits 4, 5, 6 and 7 are the dirty flags of the configuration, N, M and D registers. A flag sets when its register is written with a value that differs from the active copy. Writing a value equal to the active copy does not set it.
- R5: When an update completes, every dirty flag clears. The exception is a register written during the pending update with a value that differs from the value just applied; its flag stays set.
- R6: Shadow writes made while an update is pending are accepted and read back at once. They do not alter the transfer in progress and take effect only at the next update.
- R7: A command write with bit 0 clear starts no update. Writing bit 0 again while an update is pending neither restarts nor extends it.
- R8: Command bit 1 is a read/write root enable. `root_clk_en` follows it `SYNC_STAGES` cycles after the write. Command bit 31 reads 1 exactly when `root_clk_en` is 0.
- R9: Command bits 31 and 7:4 ignore writes. Offsets other than 0x00 to 0x10 read 0, and writes to them change no register.
- R10: `dual_edge` is 1 exactly when the active mode field equals 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| act_div | output | DIV_W | Active pre-divider value |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active counter mode |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |
| dual_edge | output | 1 | Active mode is dual-edge M/N |
| root_clk_en | output | 1 | Root clock gate enable after the sync latency |

## Verification
The hardest case to reach is a shadow write that falls inside the few cycles between an update request and its completion. Such a write must not change the values being applied, yet it must leave its dirty flag set afterwards. The bench issues the request, writes N on the very next edge, and then repeats the request on the edge after that. All three writes land inside the pending window. The bench then checks that the active N still shows the old value one cycle before completion. At completion it checks that active N takes the value from before the window, that the update bit clears on time, and that only the N dirty flag remains.

// File: rtl/clkroot_pkg.sv
// Package: shared offsets, command bit positions, field layout and the
// register-select encoding for the clock root configuration bank.
package clkroot_pkg;

    // Register byte offsets; software depends on these.
    localparam int unsigned OFS_CMD = 32'h00;
    localparam int unsigned OFS_CFG = 32'h04;
    localparam int unsigned OFS_M   = 32'h08;
    localparam int unsigned OFS_N   = 32'h0C;
    localparam int unsigned OFS_D   = 32'h10;

    // Command register bit positions.
    localparam int unsigned BIT_UPD       = 0;
    localparam int unsigned BIT_EN        = 1;
    localparam int unsigned BIT_DIRTY_CFG = 4;
    localparam int unsigned BIT_DIRTY_N   = 5;
    localparam int unsigned BIT_DIRTY_M   = 6;
    localparam int unsigned BIT_DIRTY_D   = 7;
    localparam int unsigned BIT_OFF       = 31;

    // Configuration register field layout.
    localparam int unsigned SRC_LSB  = 8;
    localparam int unsigned SRC_W    = 3;
    localparam int unsigned MODE_LSB = 12;
    localparam int unsigned MODE_W   = 2;
    localparam logic [MODE_W-1:0] MODE_DUAL = 2'd2;

    // Dirty flag indices (order matches command bits 4..7).
    localparam int unsigned DF_CFG = 0;
    localparam int unsigned DF_N   = 1;
    localparam int unsigned DF_M   = 2;
    localparam int unsigned DF_D   = 3;
    localparam int unsigned NUM_DF = 4;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_CFG,
        SEL_M,
        SEL_N,
        SEL_D
    } reg_sel_e;

endpackage

// File: rtl/clkroot_addr_decode.sv
// Module: clkroot_addr_decode
// Maps a byte offset to a register select. Any offset that is not mapped
// yields SEL_NONE.
// Assumes ADDR_W is wide enough to hold the largest offset (0x10).
module clkroot_addr_decode #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]      addr,
    output clkroot_pkg::reg_sel_e  sel
);
    import clkroot_pkg::*;

    // Full-width compare against each mapped offset.
    always_comb begin
        if (addr == ADDR_W'(OFS_CMD))      sel = SEL_CMD;
        else if (addr == ADDR_W'(OFS_CFG)) sel = SEL_CFG;
        else if (addr == ADDR_W'(OFS_M))   sel = SEL_M;
        else if (addr == ADDR_W'(OFS_N))   sel = SEL_N;
        else if (addr == ADDR_W'(OFS_D))   sel = SEL_D;
        else                               sel = SEL_NONE;
    end

endmodule

// File: rtl/clkroot_shadow_regs.sv
// Module: clkroot_shadow_regs
// Holds the software-visible shadow copies of the configuration, M, N and
// D registers. Also produces one write strobe per register.
// Assumes the field values have already been extracted from the bus data.
module clkroot_shadow_regs #(
    parameter int unsigned CFG_W = 10,
    parameter int unsigned MND_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  clkroot_pkg::reg_sel_e sel,
    input  logic [CFG_W-1:0]      w_cfg,
    input  logic [MND_W-1:0]      w_mnd,
    output logic                  wr_cfg,
    output logic                  wr_m,
    output logic                  wr_n,
    output logic                  wr_d,
    output logic [CFG_W-1:0]      sh_cfg,
    output logic [MND_W-1:0]      sh_m,
    output logic [MND_W-1:0]      sh_n,
    output logic [MND_W-1:0]      sh_d
);
    import clkroot_pkg::*;

    // Per-register write strobes.
    always_comb begin
        wr_cfg = bus_wr_en && (sel == SEL_CFG);
        wr_m   = bus_wr_en && (sel == SEL_M);
        wr_n   = bus_wr_en && (sel == SEL_N);
        wr_d   = bus_wr_en && (sel == SEL_D);
    end

    // Shadow storage, loaded by the strobes and cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_cfg <= '0;
            sh_m   <= '0;
            sh_n   <= '0;
            sh_d   <= '0;
        end else begin
            if (wr_cfg) sh_cfg <= w_cfg;
            if (wr_m)   sh_m   <= w_mnd;
            if (wr_n)   sh_n   <= w_mnd;
            if (wr_d)   sh_d   <= w_mnd;
        end
    end

endmodule

// File: rtl/clkroot_update_seq.sv
// Module: clkroot_update_seq
// On a request, snapshots the shadow payload into a staging register and
// counts SYNC_STAGES cycles. On the final cycle it loads the active copy
// and drops pending. A request while pending is ignored.
// Assumes SYNC_STAGES >= 1.
module clkroot_update_seq #(
    parameter int unsigned SYNC_STAGES = 3,
    parameter int unsigned PAYLOAD_W   = 34
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAYLOAD_W-1:0] shadow_in,
    output logic                 pending,
    output logic                 done,
    output logic [PAYLOAD_W-1:0] staged,
    output logic [PAYLOAD_W-1:0] active
);
    localparam int unsigned CNT_W = $clog2(SYNC_STAGES + 1);

    logic [CNT_W-1:0] cnt;

    // Completion happens on the edge where the countdown sits at one.
    always_comb done = pending && (cnt == CNT_W'(1));

    // Request capture, countdown, and transfer into the active copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            cnt     <= '0;
            staged  <= '0;
            active  <= '0;
        end else if (!pending) begin
            if (start) begin
                pending <= 1'b1;
                cnt     <= CNT_W'(SYNC_STAGES);
                staged  <= shadow_in;
            end
        end else if (done) begin
            pending <= 1'b0;
            cnt     <= '0;
            active  <= staged;
        end else begin
            cnt <= cnt - CNT_W'(1);
        end
    end

endmodule

// File: rtl/clkroot_dirty_track.sv
// Module: clkroot_dirty_track
// One dirty flag per shadow register. Between updates a flag sets when its
// register is written with a value that differs from the active copy. On
// the completion edge every flag is recomputed against the values being
// applied, so only writes made during the pending window stay marked.
// Assumes done is a single-cycle pulse and staged holds the values applied
// on that edge.
module clkroot_dirty_track #(
    parameter int unsigned CFG_W = 10,
    parameter int unsigned MND_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              done,
    input  logic [clkroot_pkg::NUM_DF-1:0]    wr_vec,
    input  logic [CFG_W-1:0]                  w_cfg,
    input  logic [MND_W-1:0]                  w_mnd,
    input  logic [CFG_W-1:0]                  sh_cfg,
    input  logic [MND_W-1:0]                  sh_m,
    input  logic [MND_W-1:0]                  sh_n,
    input  logic [MND_W-1:0]                  sh_d,
    input  logic [CFG_W-1:0]                  act_cfg,
    input  logic [MND_W-1:0]                  act_m,
    input  logic [MND_W-1:0]                  act_n,
    input  logic [MND_W-1:0]                  act_d,
    input  logic [CFG_W-1:0]                  stg_cfg,
    input  logic [MND_W-1:0]                  stg_m,
    input  logic [MND_W-1:0]                  stg_n,
    input  logic [MND_W-1:0]                  stg_d,
    output logic [clkroot_pkg::NUM_DF-1:0]    dirty
);
    import clkroot_pkg::*;

    localparam int unsigned FW = (CFG_W > MND_W) ? CFG_W : MND_W;

    logic [FW-1:0] cand [NUM_DF];
    logic [FW-1:0] refv [NUM_DF];

    // Candidate shadow value after this edge, and the reference it is
    // compared with: the staged values on completion, else the active ones.
    always_comb begin
        cand[DF_CFG] = wr_vec[DF_CFG] ? FW'(w_cfg) : FW'(sh_cfg);
        cand[DF_N]   = wr_vec[DF_N]   ? FW'(w_mnd) : FW'(sh_n);
        cand[DF_M]   = wr_vec[DF_M]   ? FW'(w_mnd) : FW'(sh_m);
        cand[DF_D]   = wr_vec[DF_D]   ? FW'(w_mnd) : FW'(sh_d);
        refv[DF_CFG] = done ? FW'(stg_cfg) : FW'(act_cfg);
        refv[DF_N]   = done ? FW'(stg_n)   : FW'(act_n);
        refv[DF_M]   = done ? FW'(stg_m)   : FW'(act_m);
        refv[DF_D]   = done ? FW'(stg_d)   : FW'(act_d);
    end

    for (genvar i = 0; i < NUM_DF; i++) begin : g_flag
        // Per-register flag: sticky set between updates, recomputed at done.
        always_ff @(posedge clk) begin
            if (!rst_n)
                dirty[i] <= 1'b0;
            else if (done)
                dirty[i] <= (cand[i] != refv[i]);
            else if (wr_vec[i] && (cand[i] != refv[i]))
                dirty[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/clkroot_root_gate.sv
// Module: clkroot_root_gate
// Stores the software root-enable bit and passes it through SYNC_STAGES
// flops before it reaches the clock gate. Its latency therefore matches
// the configuration update latency.
// Assumes SYNC_STAGES >= 1.
module clkroot_root_gate #(
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_val,
    output logic en_q,
    output logic root_on
);
    logic [SYNC_STAGES-1:0] pipe;

    // Software-visible enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (en_wr) en_q <= en_val;
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First synchroniser stage takes the enable bit.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= 1'b0;
                else        pipe[s] <= en_q;
            end
        end else begin : g_next
            // Later stages shift the previous stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[s] <= 1'b0;
                else        pipe[s] <= pipe[s-1];
            end
        end
    end

    always_comb root_on = pipe[SYNC_STAGES-1];

endmodule

// File: rtl/clkroot_cfg_bank.sv
// Module: clkroot_cfg_bank (top)
// Double-buffered configuration registers for one clock root generator.
// Shadow writes reach the active outputs only through an update request
// that completes SYNC_STAGES cycles later. The module also provides
// dirty-flag tracking and a root enable with the same latency.
// Assumes DATA_W = 32 (the root-off bit sits at bit 31), DIV_W <= 8 and
// MND_W <= 32. The read path is combinational from bus_addr.
module clkroot_cfg_bank #(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned DIV_W       = 5,
    parameter int unsigned MND_W       = 8,
    parameter int unsigned SYNC_STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DIV_W-1:0]  act_div,
    output logic [2:0]        act_src,
    output logic [1:0]        act_mode,
    output logic [MND_W-1:0]  act_m,
    output logic [MND_W-1:0]  act_n,
    output logic [MND_W-1:0]  act_d,
    output logic              dual_edge,
    output logic              root_clk_en
);
    import clkroot_pkg::*;

    localparam int unsigned CFG_W     = DIV_W + SRC_W + MODE_W;
    localparam int unsigned PAYLOAD_W = CFG_W + 3 * MND_W;

    reg_sel_e              sel;
    logic [CFG_W-1:0]      w_cfg;
    logic [MND_W-1:0]      w_mnd;
    logic                  wr_cfg, wr_m, wr_n, wr_d;
    logic [CFG_W-1:0]      sh_cfg;
    logic [MND_W-1:0]      sh_m, sh_n, sh_d;
    logic                  cmd_wr;
    logic                  upd_start;
    logic                  upd_pending;
    logic                  upd_done;
    logic [PAYLOAD_W-1:0]  stg_payload;
    logic [PAYLOAD_W-1:0]  act_payload;
    logic [CFG_W-1:0]      stg_cfg, act_cfg;
    logic [MND_W-1:0]      stg_m, stg_n, stg_d;
    logic [NUM_DF-1:0]     dirty_flags;
    logic                  en_q;
    logic                  unused_wdata_bits;

    // Only the implemented bit slices of the bus data are used.
    always_comb unused_wdata_bits = ^bus_wdata;

    clkroot_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    // Extract the write fields in packed order {mode, src, div}.
    always_comb begin
        w_cfg  = {bus_wdata[MODE_LSB +: MODE_W],
                  bus_wdata[SRC_LSB  +: SRC_W],
                  bus_wdata[DIV_W-1:0]};
        w_mnd  = bus_wdata[MND_W-1:0];
        cmd_wr = bus_wr_en && (sel == SEL_CMD);
        upd_start = cmd_wr && bus_wdata[BIT_UPD];
    end

    clkroot_shadow_regs #(.CFG_W(CFG_W), .MND_W(MND_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .sel       (sel),
        .w_cfg     (w_cfg),
        .w_mnd     (w_mnd),
        .wr_cfg    (wr_cfg),
        .wr_m      (wr_m),
        .wr_n      (wr_n),
        .wr_d      (wr_d),
        .sh_cfg    (sh_cfg),
        .sh_m      (sh_m),
        .sh_n      (sh_n),
        .sh_d      (sh_d)
    );

    clkroot_update_seq #(.SYNC_STAGES(SYNC_STAGES), .PAYLOAD_W(PAYLOAD_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (upd_start),
        .shadow_in ({sh_cfg, sh_m, sh_n, sh_d}),
        .pending   (upd_pending),
        .done      (upd_done),
        .staged    (stg_payload),
        .active    (act_payload)
    );

    // Unpack the staged and active payloads into their fields.
    always_comb begin
        {stg_cfg, stg_m, stg_n, stg_d} = stg_payload;
        {act_cfg, act_m, act_n, act_d} = act_payload;
        {act_mode, act_src, act_div}   = act_cfg;
        dual_edge = (act_mode == MODE_DUAL);
    end

    clkroot_dirty_track #(.CFG_W(CFG_W), .MND_W(MND_W)) u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (upd_done),
        .wr_vec  ({wr_d, wr_m, wr_n, wr_cfg}),
        .w_cfg   (w_cfg),
        .w_mnd   (w_mnd),
        .sh_cfg  (sh_cfg),
        .sh_m    (sh_m),
        .sh_n    (sh_n),
        .sh_d    (sh_d),
        .act_cfg (act_cfg),
        .act_m   (act_m),
        .act_n   (act_n),
        .act_d   (act_d),
        .stg_cfg (stg_cfg),
        .stg_m   (stg_m),
        .stg_n   (stg_n),
        .stg_d   (stg_d),
        .dirty   (dirty_flags)
    );

    clkroot_root_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (cmd_wr),
        .en_val  (bus_wdata[BIT_EN]),
        .en_q    (en_q),
        .root_on (root_clk_en)
    );

    // Read multiplexer; unimplemented bits and unmapped offsets read zero.
    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_CMD: begin
                bus_rdata[BIT_UPD]       = upd_pending;
                bus_rdata[BIT_EN]        = en_q;
                bus_rdata[BIT_DIRTY_CFG] = dirty_flags[DF_CFG];
                bus_rdata[BIT_DIRTY_N]   = dirty_flags[DF_N];
                bus_rdata[BIT_DIRTY_M]   = dirty_flags[DF_M];
                bus_rdata[BIT_DIRTY_D]   = dirty_flags[DF_D];
                bus_rdata[BIT_OFF]       = ~root_clk_en;
            end
            SEL_CFG: begin
                bus_rdata[DIV_W-1:0]          = sh_cfg[DIV_W-1:0];
                bus_rdata[SRC_LSB +: SRC_W]   = sh_cfg[DIV_W +: SRC_W];
                bus_rdata[MODE_LSB +: MODE_W] = sh_cfg[DIV_W+SRC_W +: MODE_W];
            end
            SEL_M:   bus_rdata[MND_W-1:0] = sh_m;
            SEL_N:   bus_rdata[MND_W-1:0] = sh_n;
            SEL_D:   bus_rdata[MND_W-1:0] = sh_d;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/clkroot_cfg_bank_chk.sv
// Module: clkroot_cfg_bank_chk
// Assertion checker bound into clkroot_cfg_bank. It observes ports and the
// internal pending, dirty and shadow state. The length of the update window
// is measured with a counter, not a deep $past.
module clkroot_cfg_bank_chk #(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DIV_W       = 5,
    parameter int unsigned MND_W       = 8,
    parameter int unsigned SYNC_STAGES = 3,
    parameter int unsigned CFG_W       = DIV_W + 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              wdata_upd,
    input logic [DIV_W-1:0]  act_div,
    input logic [2:0]        act_src,
    input logic [1:0]        act_mode,
    input logic [MND_W-1:0]  act_m,
    input logic [MND_W-1:0]  act_n,
    input logic [MND_W-1:0]  act_d,
    input logic              root_clk_en,
    input logic              upd_pending,
    input logic [3:0]        dirty_flags,
    input logic [CFG_W-1:0]  sh_cfg,
    input logic [MND_W-1:0]  sh_m,
    input logic [MND_W-1:0]  sh_n,
    input logic [MND_W-1:0]  sh_d
);
    localparam int unsigned BC_W = $clog2(SYNC_STAGES + 2);

    logic [BC_W-1:0] busy_cnt;

    // Count the cycles spent with an update pending.
    always_ff @(posedge clk) begin
        if (!rst_n || !upd_pending) busy_cnt <= '0;
        else                        busy_cnt <= busy_cnt + BC_W'(1);
    end

    // R1: the first cycle after reset shows zero fields and the root off.
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ({act_div, act_src, act_mode, act_m, act_n, act_d} == '0
                           && !root_clk_en));

    // R3: active fields move only on the edge that ends a pending update.
    p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(upd_pending) |-> $stable({act_div, act_src, act_mode, act_m, act_n, act_d}));

    // R3: the pending window lasts exactly SYNC_STAGES cycles.
    p_window_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |-> (busy_cnt == BC_W'(SYNC_STAGES)));

    p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= BC_W'(SYNC_STAGES));

    // R7: an update only begins after a command write carrying bit 0.
    p_start_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_pending) |-> $past(bus_wr_en && bus_addr == '0 && wdata_upd));

    // R5: after completion a flag survives only where shadow differs from active.
    p_dirty_after_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pending) |->
            ((!dirty_flags[0] || sh_cfg != {act_mode, act_src, act_div}) &&
             (!dirty_flags[1] || sh_n != act_n) &&
             (!dirty_flags[2] || sh_m != act_m) &&
             (!dirty_flags[3] || sh_d != act_d)));

endmodule

bind clkroot_cfg_bank clkroot_cfg_bank_chk #(
    .ADDR_W      (ADDR_W),
    .DIV_W       (DIV_W),
    .MND_W       (MND_W),
    .SYNC_STAGES (SYNC_STAGES),
    .CFG_W       (CFG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_en   (bus_wr_en),
    .bus_addr    (bus_addr),
    .wdata_upd   (bus_wdata[0]),
    .act_div     (act_div),
    .act_src     (act_src),
    .act_mode    (act_mode),
    .act_m       (act_m),
    .act_n       (act_n),
    .act_d       (act_d),
    .root_clk_en (root_clk_en),
    .upd_pending (upd_pending),
    .dirty_flags (dirty_flags),
    .sh_cfg      (sh_cfg),
    .sh_m        (sh_m),
    .sh_n        (sh_n),
    .sh_d        (sh_d)
);

// File: tb/clkroot_cfg_bank_tb.sv
// Bench for clkroot_cfg_bank: a vector table of register writes and
// readbacks, then directed tests of update timing, dirty flags, root
// enable and reset. Inputs are driven and outputs sampled at negedge.
module clkroot_cfg_bank_tb;

    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned DIV_W  = 5;
    localparam int unsigned MND_W  = 8;
    localparam int unsigned SYNC   = 3;

    localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_M = 5'h08,
                           A_N = 5'h0C, A_D = 5'h10;

    // {offset, write data, expected readback at the same offset}
    localparam int NVEC = 10;
    localparam logic [68:0] VEC [NVEC] = '{
        {A_CFG, 32'hFFFF_FFFF, 32'h0000_371F},
        {A_M,   32'h0000_1234, 32'h0000_0034},
        {A_N,   32'hFFFF_ABCD, 32'h0000_00CD},
        {A_D,   32'h0000_FF00, 32'h0000_0000},
        {5'h14, 32'hDEAD_BEEF, 32'h0000_0000},
        {A_CFG, 32'h0000_2205, 32'h0000_2205},
        {A_M,   32'h0000_0003, 32'h0000_0003},
        {A_N,   32'h0000_00FA, 32'h0000_00FA},
        {A_D,   32'h0000_00F7, 32'h0000_00F7},
        {5'h1C, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr_en = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [DIV_W-1:0]  act_div;
    logic [2:0]        act_src;
    logic [1:0]        act_mode;
    logic [MND_W-1:0]  act_m, act_n, act_d;
    logic              dual_edge;
    logic              root_clk_en;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd;

    always #5 clk = ~clk;

    clkroot_cfg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W),
        .MND_W(MND_W), .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .act_div(act_div),
        .act_src(act_src), .act_mode(act_mode), .act_m(act_m), .act_n(act_n),
        .act_d(act_d), .dual_edge(dual_edge), .root_clk_en(root_clk_en)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] act_word();
        return {2'b0, act_mode, 1'b0, act_src, 3'b0, act_div, act_m, act_n};
    endfunction

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1: reset state
        rdreg(A_CMD, rd); chk("R1 cmd after reset", rd, 32'h8000_0000);
        rdreg(A_CFG, rd); chk("R1 cfg shadow after reset", rd, 32'h0);
        chk("R1 active fields after reset", act_word() | {act_d, 24'h0}, 32'h0);
        chk("R1 root enable after reset", {31'h0, root_clk_en}, 32'h0);

        // R2 / R9: table of writes and readbacks
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i][68:64], VEC[i][63:32]);
            rdreg(VEC[i][68:64], rd);
            chk($sformatf("R2 readback vector %0d", i), rd, VEC[i][31:0]);
        end
        chk("R2 active unchanged by shadow writes", act_word() | {act_d, 24'h0}, 32'h0);
        rdreg(A_CFG, rd); chk("R9 unmapped write left cfg", rd, 32'h0000_2205);
        rdreg(A_D, rd);   chk("R9 unmapped write left D", rd, 32'h0000_00F7);
        rdreg(A_CMD, rd); chk("R4 all dirty flags set", rd, 32'h8000_00F0);

        // R3: update timing
        wr(A_CMD, 32'h1);
        rdreg(A_CMD, rd); chk("R3 update bit reads 1", rd, 32'h8000_00F1);
        tick(SYNC - 1);
        chk("R3 active held before completion", {27'h0, act_div}, 32'h0);
        tick(1);
        chk("R3 div applied", {27'h0, act_div}, 32'h5);
        chk("R3 src applied", {29'h0, act_src}, 32'h2);
        chk("R3 m applied", {24'h0, act_m}, 32'h03);
        chk("R3 n applied", {24'h0, act_n}, 32'hFA);
        chk("R3 d applied", {24'h0, act_d}, 32'hF7);
        chk("R10 dual edge for mode 2", {31'h0, dual_edge}, 32'h1);
        rdreg(A_CMD, rd); chk("R5 dirty and update cleared", rd, 32'h8000_0000);

        // R4: equal write leaves flag clear, differing write sets it
        wr(A_M, 32'h03);
        wr(A_N, 32'h12);
        rdreg(A_CMD, rd); chk("R4 only N dirty", rd, 32'h8000_0020);

        // R6 / R7 / R5: writes inside the pending window
        wr(A_CMD, 32'h1);
        wr(A_N, 32'h34);
        rdreg(A_N, rd); chk("R6 shadow write accepted while pending", rd, 32'h34);
        wr(A_CMD, 32'h1);
        chk("R6 active N held during window", {24'h0, act_n}, 32'hFA);
        rdreg(A_CMD, rd); chk("R7 still pending before completion", rd, 32'h8000_0021);
        tick(1);
        chk("R6 pending applies request-time N", {24'h0, act_n}, 32'h12);
        rdreg(A_CMD, rd); chk("R7 R5 not extended, N stays dirty", rd, 32'h8000_0020);
        wr(A_CMD, 32'h1);
        tick(SYNC);
        chk("R6 window write applied on next update", {24'h0, act_n}, 32'h34);
        rdreg(A_CMD, rd); chk("R5 flags clear after second update", rd, 32'h8000_0000);

        // R8: root enable latency; R7: no update from bit 0 clear
        wr(A_CMD, 32'h2);
        rdreg(A_CMD, rd); chk("R8 enable bit set, root still off", rd, 32'h8000_0002);
        tick(SYNC - 1);
        chk("R8 root gate not yet on", {31'h0, root_clk_en}, 32'h0);
        tick(1);
        chk("R8 root gate on", {31'h0, root_clk_en}, 32'h1);
        rdreg(A_CMD, rd); chk("R8 R7 off status clear, no update", rd, 32'h0000_0002);

        // R9: read-only command bits ignore writes
        wr(A_CMD, 32'h8000_00F2);
        rdreg(A_CMD, rd); chk("R9 read-only bits ignore writes", rd, 32'h0000_0002);
        wr(A_CMD, 32'h0);
        tick(SYNC);
        rdreg(A_CMD, rd); chk("R8 root off again", rd, 32'h8000_0000);

        // R10: mode 1 is not dual-edge
        wr(A_CFG, 32'h0000_1003);
        wr(A_CMD, 32'h1);
        tick(SYNC);
        chk("R10 mode 1 applied", {30'h0, act_mode}, 32'h1);
        chk("R10 dual edge low for mode 1", {31'h0, dual_edge}, 32'h0);
        chk("R3 div from new cfg", {27'h0, act_div}, 32'h3);

        // R1: reset in the middle of operation
        wr(A_CMD, 32'h2);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        rdreg(A_CMD, rd); chk("R1 cmd after second reset", rd, 32'h8000_0000);
        rdreg(A_N, rd);   chk("R1 N shadow after second reset", rd, 32'h0);
        chk("R1 active after second reset", act_word() | {act_d, 24'h0}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule